// File: doc/BRIEF.md
# Comparator-Driven Set/Reset Latch Controller

This block holds a single set/reset latch for a small peripheral that sits next to two analog comparators. A software-visible 8-bit control register decides which events may move the latch. A high result from the first comparator can set it and a high result from the second can clear it, each only when its own enable bit is on. Software can also force a one-shot set or clear by writing 1 to a self-clearing bit. When a set and a clear arrive in the same clock cycle, the clear wins.

Each of the two output pins picks, through its own select bit, either the latch state or the raw result of the comparator it belongs to. A separate status output always reports the raw comparator results, whatever the latch configuration. One more register bit enables a voltage reference; it is brought out as a plain level and has no other effect here. The comparator results arrive already synchronous to the block clock.

Top module: `srlatch_ctrl`

## Requirements
- R1: After synchronous reset, `rd_data` reads 8'h00, the latch holds 0 and `ref_en` is 0.
- R2: A write with `wr_en` loads bits 7, 6, 5, 4 and 0 of `wr_data` into the register, and from the next cycle they read back at the same positions of `rd_data`. Bits 3, 2 and 1 of `rd_data` always read 0.
- R3: When bit 5 (set enable) is 1 and `cmp_res[0]` is high in a cycle, the latch is 1 after that clock edge, unless a clear is also active. When bit 5 is 0, `cmp_res[0]` does not change the latch.
- R4: When bit 4 (clear enable) is 1 and `cmp_res[1]` is high in a cycle, the latch is 0 after that clock edge. When bit 4 is 0, `cmp_res[1]` does not change the latch.
- R5: Writing 1 to bit 3 (pulse set) makes an internal set strobe that lasts exactly one cycle, starting the cycle after the write. The latch is 1 after the second clock edge counted from the write edge.
- R6: Writing 1 to bit 2 (pulse clear) makes a one-cycle clear strobe with the same timing, and the latch is then 0.
- R7: When any set source and any clear source are active in the same cycle, the latch becomes 0.
- R8: `pin_out[0]` equals the latch state when bit 6 is 1. When bit 6 is 0, it equals `cmp_res[0]`.
- R9: `pin_out[1]` equals the latch state when bit 7 is 1. When bit 7 is 0, it equals `cmp_res[1]`.
- R10: `cmp_stat` always equals `cmp_res`, whatever the register holds.
- R11: `ref_en` follows register bit 0 and has no effect on the latch or the pins.
- R12: In a cycle with no active set or clear source, the latch keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| cmp_res | input | 2 | Comparator results, index 0 = comparator 1 |
| pin_out | output | 2 | Output pin levels, index 0 = comparator-1 pin |
| cmp_stat | output | 2 | Raw comparator status |
| ref_en | output | 1 | Voltage reference enable level |

## Verification
The latch is only visible through a pin whose select bit is 1, so the bench keeps both selects on for most of the directed sequence. A wrong latch state then shows on `pin_out` in the cycle right after the edge that should have moved it. A pulse strobe that lasts too long or too short, or a wrong priority, shows up as a latch value that differs from the model one edge later. A register bit stored in the wrong place shows on `rd_data` in the cycle after the write, and on the pin mux as soon as a comparator input differs from the latch.

// File: rtl/srl_pkg.sv
package srl_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_PINS = 2;

  // control register bit positions
  localparam int B_SEL1   = 7;  // pin 1 (comparator-2 pin) select
  localparam int B_SEL0   = 6;  // pin 0 (comparator-1 pin) select
  localparam int B_SETEN  = 5;  // comparator 1 may set latch
  localparam int B_CLREN  = 4;  // comparator 2 may clear latch
  localparam int B_PSET   = 3;  // one-shot set
  localparam int B_PCLR   = 2;  // one-shot clear
  localparam int B_REFEN  = 0;  // reference enable level

  typedef struct packed {
    logic [NUM_PINS-1:0] sel;
    logic                set_en;
    logic                clr_en;
    logic                ref_en;
  } ctrl_t;
endpackage

// File: rtl/srl_ctrl_reg.sv
module srl_ctrl_reg
  import srl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output ctrl_t            ctrl,
  output logic             pset_q,
  output logic             pclr_q,
  output logic [REG_W-1:0] rd_data
);
  logic unused_bit1;
  assign unused_bit1 = wr_data[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      pset_q <= 1'b0;
      pclr_q <= 1'b0;
    end else begin
      // strobes live for one cycle; hardware drops them unless rewritten
      pset_q <= wr_en & wr_data[B_PSET];
      pclr_q <= wr_en & wr_data[B_PCLR];
      if (wr_en) begin
        ctrl.sel[1] <= wr_data[B_SEL1];
        ctrl.sel[0] <= wr_data[B_SEL0];
        ctrl.set_en <= wr_data[B_SETEN];
        ctrl.clr_en <= wr_data[B_CLREN];
        ctrl.ref_en <= wr_data[B_REFEN];
      end
    end
  end

  always_comb begin
    rd_data          = '0;
    rd_data[B_SEL1]  = ctrl.sel[1];
    rd_data[B_SEL0]  = ctrl.sel[0];
    rd_data[B_SETEN] = ctrl.set_en;
    rd_data[B_CLREN] = ctrl.clr_en;
    rd_data[B_REFEN] = ctrl.ref_en;
  end
endmodule

// File: rtl/srl_core.sv
module srl_core (
  input  logic clk,
  input  logic rst,
  input  logic set_en,
  input  logic clr_en,
  input  logic cmp_set,
  input  logic cmp_clr,
  input  logic pset,
  input  logic pclr,
  output logic latch_q
);
  logic set_src, clr_src;

  assign set_src = (set_en & cmp_set) | pset;
  assign clr_src = (clr_en & cmp_clr) | pclr;

  always_ff @(posedge clk) begin
    if (rst)          latch_q <= 1'b0;
    else if (clr_src) latch_q <= 1'b0;   // clear has priority
    else if (set_src) latch_q <= 1'b1;
  end
endmodule

// File: rtl/srl_outmux.sv
module srl_outmux
  import srl_pkg::*;
(
  input  logic [NUM_PINS-1:0] sel,
  input  logic                latch_q,
  input  logic [NUM_PINS-1:0] cmp_res,
  output logic [NUM_PINS-1:0] pin_out
);
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign pin_out[g] = sel[g] ? latch_q : cmp_res[g];
  end
endmodule

// File: rtl/srlatch_ctrl.sv
module srlatch_ctrl
  import srl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic [NUM_PINS-1:0] cmp_res,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] cmp_stat,
  output logic             ref_en
);
  ctrl_t ctrl;
  logic  pset_q, pclr_q, latch_q;

  srl_ctrl_reg u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl(ctrl), .pset_q(pset_q), .pclr_q(pclr_q), .rd_data(rd_data)
  );

  srl_core u_core (
    .clk(clk), .rst(rst),
    .set_en(ctrl.set_en), .clr_en(ctrl.clr_en),
    .cmp_set(cmp_res[0]), .cmp_clr(cmp_res[1]),
    .pset(pset_q), .pclr(pclr_q), .latch_q(latch_q)
  );

  srl_outmux u_mux (
    .sel(ctrl.sel), .latch_q(latch_q), .cmp_res(cmp_res), .pin_out(pin_out)
  );

  assign cmp_stat = cmp_res;
  assign ref_en   = ctrl.ref_en;
endmodule

// File: rtl/srl_checker.sv
module srl_checker (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic [1:0] cmp_res,
  input logic       pset_q,
  input logic       pclr_q,
  input logic       latch_q
);
  logic clr_any, set_any;
  assign clr_any = pclr_q | (rd_data[4] & cmp_res[1]);
  assign set_any = pset_q | (rd_data[5] & cmp_res[0]);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rd_data == 8'h00 && !latch_q)); // R1
  AST_RD_ZEROS: assert property (@(posedge clk) disable iff (rst)
    rd_data[3:1] == 3'b000); // R2
  AST_CMP_SET: assert property (@(posedge clk) disable iff (rst)
    (rd_data[5] && cmp_res[0] && !clr_any) |=> latch_q); // R3
  AST_CMP_CLR: assert property (@(posedge clk) disable iff (rst)
    (rd_data[4] && cmp_res[1]) |=> !latch_q); // R4
  AST_PSET_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (pset_q && !(wr_en && wr_data[3])) |=> !pset_q); // R5
  AST_PCLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    pclr_q |=> !latch_q); // R6
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    (set_any && clr_any) |=> !latch_q); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!set_any && !clr_any) |=> $stable(latch_q)); // R12
endmodule

bind srlatch_ctrl srl_checker u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .cmp_res(cmp_res),
  .pset_q(pset_q), .pclr_q(pclr_q), .latch_q(latch_q)
);

// File: tb/tb_srlatch_ctrl.sv
`timescale 1ns/1ps
module tb_srlatch_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [1:0] cmp_res = 2'b00;
  logic [1:0] pin_out, cmp_stat;
  logic       ref_en;

  int tests = 0, fails = 0;

  // behavioural reference state
  logic [7:0] m_reg;   // readable image
  bit         m_ps, m_pc, m_q;

  srlatch_ctrl dut (.*);

  always #5 clk = ~clk;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit m_pin(int i);
    if (i == 0) return m_reg[6] ? m_q : cmp_res[0];
    return m_reg[7] ? m_q : cmp_res[1];
  endfunction

  // compare every output against the model mid-cycle
  task automatic cmp_all();
    chk("R2 rd_data", rd_data, m_reg);
    chk("R8 pin_out[0]", pin_out[0], m_pin(0));
    chk("R9 pin_out[1]", pin_out[1], m_pin(1));
    chk("R10 cmp_stat", cmp_stat, cmp_res);
    chk("R11 ref_en", ref_en, m_reg[0]);
  endtask

  // drive one cycle, check, then advance model over the edge
  task automatic step(input bit w, input logic [7:0] d, input logic [1:0] c);
    bit set_s, clr_s;
    wr_en = w; wr_data = d; cmp_res = c;
    #3;
    cmp_all();
    @(posedge clk);
    clr_s = m_pc || (m_reg[4] && c[1]);
    set_s = m_ps || (m_reg[5] && c[0]);
    if (clr_s) m_q = 1'b0;
    else if (set_s) m_q = 1'b1;
    m_ps = w && d[3];
    m_pc = w && d[2];
    if (w) m_reg = d & 8'hF1;
    #1;
  endtask

  task automatic look(input bit e0, input bit e1, input string tag);
    #2;
    chk({tag, " pin_out[0]"}, pin_out[0], e0);
    chk({tag, " pin_out[1]"}, pin_out[1], e1);
  endtask

  initial begin
    m_reg = 8'h00; m_ps = 0; m_pc = 0; m_q = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #2;
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 ref_en", ref_en, 0);
    chk("R1 pin_out", pin_out, 2'b00);

    step(1, 8'hC0, 2'b00);             // both pins show latch
    step(0, 8'h00, 2'b01);             // set enable off
    look(0, 0, "R3 no-effect");
    step(1, 8'hE0, 2'b00);
    step(0, 8'h00, 2'b01);
    look(1, 1, "R3 set");
    step(0, 8'h00, 2'b10);             // clear enable off
    look(1, 1, "R4 no-effect R12");
    step(0, 8'h00, 2'b00);
    look(1, 1, "R12 hold");
    step(1, 8'hF0, 2'b00);
    step(0, 8'h00, 2'b10);
    look(0, 0, "R4 clear");
    step(1, 8'hC8, 2'b00);             // pulse set
    #2 chk("R5 rd bit3", rd_data[3], 0);
    look(0, 0, "R5 before");
    step(0, 8'h00, 2'b00);
    look(1, 1, "R5 set");
    step(1, 8'hC4, 2'b00);             // pulse clear
    step(0, 8'h00, 2'b00);
    look(0, 0, "R6 clear");
    step(1, 8'hC8, 2'b00);
    step(0, 8'h00, 2'b00);
    step(1, 8'hCC, 2'b00);             // both pulses
    step(0, 8'h00, 2'b00);
    look(0, 0, "R7 pulses");
    step(1, 8'hF0, 2'b00);
    step(1, 8'hF8, 2'b00);
    step(0, 8'h00, 2'b00);
    look(1, 1, "R7 preset");
    step(0, 8'h00, 2'b11);             // comparator set and clear
    look(0, 0, "R7 comparators");
    step(1, 8'hFF, 2'b00);
    #2 chk("R2 readback", rd_data, 8'hF1);
    step(1, 8'h01, 2'b01);
    step(0, 8'h00, 2'b10);
    look(0, 1, "R8 R9 raw");
    chk("R10 status", cmp_stat, 2'b10);
    chk("R11 ref", ref_en, 1);

    for (int i = 0; i < 400; i++)
      step(($urandom % 4) == 0, 8'($urandom), 2'($urandom));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule